// File: doc/BRIEF.md
# Four-Stack Operand Register File

This block is the operand store of a small 16-bit processor. It keeps four interchangeable 16-bit hardware stacks. Each one is 16 entries deep and kept as a ring buffer with a top index and an occupancy count. The block decodes the operand part of each 16-bit instruction word. It presents a source operand and a destination operand to an external ALU during the same cycle. At the clock edge that ends the cycle, it takes the ALU result back.

Four mode bits in the instruction set, per stack, how that stack behaves while the instruction references it. With the bit set, the stack works as a plain register: its top is read or overwritten. With the bit clear, a read pops the stack and a write pushes onto it.

Stack 0 also holds interrupt return addresses. A dedicated push and pop path takes precedence over any instruction access to stack 0 in the same cycle.

Top module: `quad_stack_regfile`

## Requirements
- R1: The source index is taken from `instr[1:0]` and the destination index from `instr[3:2]`. The mode bit for stack i is `instr[4+i]`, where 1 means register behaviour and 0 means stack behaviour. `instr[15:8]` has no effect on the block.
- R2: For a valid instruction with its source stack in stack mode, `src_data` shows the current top of that stack. At the clock edge that stack loses one entry.
- R3: For a valid instruction with its source stack in register mode, `src_data` shows the top and the stack keeps its contents and depth.
- R4: A valid instruction with `wr_en` writes `wr_data` to its destination stack. In stack mode the value is pushed. In register mode it overwrites the top; if that stack is empty, it becomes the single entry.
- R5: When `two_op` is high, `dst_data` shows the destination top. A stack-mode destination is popped for that operand and then pushed with the result, so its top is replaced and its depth is unchanged.
- R6: When source and destination name the same stack in stack mode, it is popped only once. Both operands see the same old top, and with a write the net depth is unchanged.
- R7: A stack-mode pop of an empty stack returns zero, leaves the stack empty and sets sticky bit i of `unf`. A register-mode read of an empty stack returns zero and sets no flag.
- R8: A push onto a stack holding 16 entries discards the oldest entry and keeps the depth at 16. It also sets sticky bit i of `ovf`.
- R9: `irq_push` pushes `irq_pc` onto stack 0. `ret_pc` always shows the top of stack 0, or zero when it is empty. `irq_pop` pops stack 0 and follows the same underflow rule as R7. When both are high, only the push takes place.
- R10: While `irq_push` or `irq_pop` is high, every instruction access to stack 0 is suppressed. An operand taken from stack 0 reads zero, and the instruction neither moves nor writes stack 0.
- R11: A synchronous active-high `rst` empties all four stacks and clears `ovf` and `unf`.
- R12: All four stacks update at the same clock edge, and each one is affected only by the accesses that address it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | The instruction word is executed in this cycle |
| instr | input | 16 | Instruction word; the operand fields are decoded |
| two_op | input | 1 | The operation also reads its destination |
| wr_en | input | 1 | Write the ALU result to the destination |
| wr_data | input | 16 | ALU result |
| irq_push | input | 1 | Push the interrupt return address onto stack 0 |
| irq_pop | input | 1 | Pop the return address from stack 0 |
| irq_pc | input | 16 | Return address to push |
| src_data | output | 16 | Source operand |
| dst_data | output | 16 | Destination operand |
| ret_pc | output | 16 | Top of stack 0 |
| ovf | output | 4 | Sticky overflow flag per stack |
| unf | output | 4 | Sticky underflow flag per stack |

## Verification
The assertions check on every cycle, at the ports, the properties that need no stored history:
- the overflow and underflow flags never clear outside reset;
- an interrupt push shows up on `ret_pc` at the next cycle;
- both operands read zero from stack 0 while the interrupt path holds it.

The depth and content rules need a memory of earlier pushes: popping on read, overwriting in register mode, the single pop when source and destination are the same stack, and discarding the oldest entry when full. Only the bench's queue model can show these, by comparing every cycle across directed and random scenarios.

// File: rtl/quad_stack_regfile.sv
module quad_stack_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         instr_valid,
  input  logic [15:0]  instr,
  input  logic         two_op,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_push,
  input  logic         irq_pop,
  input  logic [W-1:0] irq_pc,
  output logic [W-1:0] src_data,
  output logic [W-1:0] dst_data,
  output logic [W-1:0] ret_pc,
  output logic [3:0]   ovf,
  output logic [3:0]   unf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [1:0] src_sel, dst_sel;
  logic [3:0] mode;
  logic       irq_any;
  logic [3:0][W-1:0] tops;

  assign src_sel = instr[1:0];
  assign dst_sel = instr[3:2];
  assign mode    = instr[7:4];
  assign irq_any = irq_push | irq_pop;

  for (genvar g = 0; g < 4; g++) begin : g_stk
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] top;
    logic [CW-1:0] cnt;
    logic          of_r, uf_r;

    wire blk   = (g == 0) && irq_any;
    wire rd    = instr_valid && !blk && ((src_sel == g) || (two_op && dst_sel == g));
    wire wr    = instr_valid && wr_en && !blk && (dst_sel == g);
    wire ipush = (g == 0) && irq_push;
    wire ipop  = (g == 0) && irq_pop && !irq_push;
    wire empty = (cnt == '0);
    wire pop   = ipop || (rd && !mode[g]);
    wire push  = ipush || (wr && (!mode[g] || empty));
    wire ovw   = wr && mode[g] && !empty;
    wire epop  = pop && !empty;

    wire [AW-1:0] tp   = epop ? top - AW'(1) : top;
    wire [CW-1:0] cp   = epop ? cnt - CW'(1) : cnt;
    wire          full = (cp == CW'(DEPTH));
    wire [AW-1:0] nxt  = tp + AW'(1);
    wire [W-1:0]  wv   = ipush ? irq_pc : wr_data;

    always_ff @(posedge clk) begin
      if (rst) begin
        top  <= '0;
        cnt  <= '0;
        of_r <= 1'b0;
        uf_r <= 1'b0;
      end else begin
        if (pop && empty) uf_r <= 1'b1;
        if (push) begin
          top <= nxt;
          cnt <= full ? cp : cp + CW'(1);
          if (full) of_r <= 1'b1;
        end else begin
          top <= tp;
          cnt <= cp;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst) begin
        if (push)     mem[nxt] <= wv;
        else if (ovw) mem[top] <= wr_data;
      end
    end

    assign tops[g] = empty ? '0 : mem[top];
    assign ovf[g]  = of_r;
    assign unf[g]  = uf_r;
  end

  assign src_data = (irq_any && src_sel == 2'd0) ? '0 : tops[src_sel];
  assign dst_data = (irq_any && dst_sel == 2'd0) ? '0 : tops[dst_sel];
  assign ret_pc   = tops[0];
endmodule

module quad_stack_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [15:0]  instr,
  input logic         irq_push,
  input logic         irq_pop,
  input logic [W-1:0] irq_pc,
  input logic [W-1:0] src_data,
  input logic [W-1:0] dst_data,
  input logic [W-1:0] ret_pc,
  input logic [3:0]   ovf,
  input logic [3:0]   unf
);
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((unf & $past(unf)) == $past(unf))); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ovf & $past(ovf)) == $past(ovf))); // R8
  AST_IRQ_RET_TOP: assert property (@(posedge clk) disable iff (rst)
    irq_push |=> (ret_pc == $past(irq_pc))); // R9
  AST_IRQ_BLOCK_SRC: assert property (@(posedge clk) disable iff (rst)
    ((irq_push || irq_pop) && instr[1:0] == 2'd0) |-> (src_data == '0)); // R10
  AST_IRQ_BLOCK_DST: assert property (@(posedge clk) disable iff (rst)
    ((irq_push || irq_pop) && instr[3:2] == 2'd0) |-> (dst_data == '0)); // R10
endmodule

bind quad_stack_regfile quad_stack_checker #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .instr(instr), .irq_push(irq_push), .irq_pop(irq_pop),
  .irq_pc(irq_pc), .src_data(src_data), .dst_data(dst_data), .ret_pc(ret_pc),
  .ovf(ovf), .unf(unf));

// File: tb/test_quad_stack_regfile.sv
`timescale 1ns/1ps
module test_quad_stack_regfile;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, instr_valid, two_op, wr_en, irq_push, irq_pop;
  logic [15:0] instr, wr_data, irq_pc;
  logic [15:0] src_data, dst_data, ret_pc;
  logic [3:0]  ovf, unf;

  quad_stack_regfile i_quad_stack_regfile (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .two_op(two_op),
    .wr_en(wr_en), .wr_data(wr_data), .irq_push(irq_push), .irq_pop(irq_pop),
    .irq_pc(irq_pc), .src_data(src_data), .dst_data(dst_data), .ret_pc(ret_pc),
    .ovf(ovf), .unf(unf));

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] mq [4][$];
  logic [3:0]  m_ovf, m_unf;

  function automatic logic [15:0] mk(input logic [3:0] md, input int d, input int s);
    return {8'hC3, md, 2'(d), 2'(s)};
  endfunction

  function automatic logic [15:0] mtop(input int i);
    return (mq[i].size() == 0) ? 16'h0 : mq[i][$];
  endfunction

  task automatic mpush(input int i, input logic [15:0] v);
    if (mq[i].size() == 16) begin
      void'(mq[i].pop_front());
      m_ovf[i] = 1'b1;
    end
    mq[i].push_back(v);
  endtask

  task automatic step(input string tag, input logic r, input logic v, input logic [15:0] ins,
                      input logic two, input logic we, input logic [15:0] wd,
                      input logic ip, input logic ipp, input logic [15:0] ipc);
    logic [15:0] es, ed, er;
    logic blk;
    int s, d;
    rst = r; instr_valid = v; instr = ins; two_op = two; wr_en = we; wr_data = wd;
    irq_push = ip; irq_pop = ipp; irq_pc = ipc;
    #1;
    s = int'(ins[1:0]); d = int'(ins[3:2]);
    blk = ip | ipp;
    es = (blk && s == 0) ? 16'h0 : mtop(s);
    ed = (blk && d == 0) ? 16'h0 : mtop(d);
    er = mtop(0);
    total++;
    if (src_data !== es || dst_data !== ed || ret_pc !== er || ovf !== m_ovf || unf !== m_unf) begin
      bad++;
      $display("FAIL %s: src=%h dst=%h ret=%h ovf=%b unf=%b expected src=%h dst=%h ret=%h ovf=%b unf=%b",
               tag, src_data, dst_data, ret_pc, ovf, unf, es, ed, er, m_ovf, m_unf);
    end
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < 4; i++) mq[i].delete();
      m_ovf = '0; m_unf = '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        bit b, rd, wr, md;
        b  = (i == 0) && blk;
        md = ins[4+i];
        rd = v && !b && (s == i || (two && d == i));
        wr = v && we && !b && d == i;
        if ((rd && !md) || (i == 0 && ipp && !ip)) begin
          if (mq[i].size() == 0) m_unf[i] = 1'b1;
          else void'(mq[i].pop_back());
        end
        if (i == 0 && ip) mpush(0, ipc);
        else if (wr) begin
          if (!md || mq[i].size() == 0) mpush(i, wd);
          else mq[i][mq[i].size()-1] = wd;
        end
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_ovf = '0; m_unf = '0;
    rst = 1; instr_valid = 0; instr = '0; two_op = 0; wr_en = 0; wr_data = '0;
    irq_push = 0; irq_pop = 0; irq_pc = '0;
    @(negedge clk);
    step("R11", 1, 0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0);
    step("R11", 0, 0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0);
    // R4 stack-mode pushes, source stack 3 read in register mode (R1 R3)
    for (int k = 0; k < 3; k++)
      step("R4", 0, 1, mk(4'b1000, 1, 3), 0, 1, 16'h1100 + 16'(k), 0, 0, 16'h0);
    for (int k = 0; k < 2; k++)
      step("R12", 0, 1, mk(4'b1000, 2, 3), 0, 1, 16'h2200 + 16'(k), 0, 0, 16'h0);
    step("R3", 0, 1, mk(4'b0010, 2, 1), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R3", 0, 1, mk(4'b0010, 2, 1), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R1", 0, 1, {8'hFF, 4'b0010, 2'd2, 2'd1}, 0, 0, 16'h0, 0, 0, 16'h0);
    step("R2", 0, 1, mk(4'b0000, 3, 1), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R4", 0, 1, mk(4'b0100, 2, 1), 0, 1, 16'hBEEF, 0, 0, 16'h0);
    step("R5", 0, 1, mk(4'b0010, 2, 1), 1, 1, 16'h5A5A, 0, 0, 16'h0);
    step("R5", 0, 1, mk(4'b0010, 2, 1), 1, 0, 16'h0, 0, 0, 16'h0);
    step("R6", 0, 1, mk(4'b0000, 1, 1), 1, 1, 16'h6666, 0, 0, 16'h0);
    step("R6", 0, 1, mk(4'b0000, 1, 1), 0, 0, 16'h0, 0, 0, 16'h0);
    // R7 underflow on empty stack 3, register read of empty stack 3
    step("R7", 0, 1, mk(4'b1000, 2, 3), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R7", 0, 1, mk(4'b0100, 2, 3), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R7", 0, 1, mk(4'b0100, 2, 3), 0, 0, 16'h0, 0, 0, 16'h0);
    step("R4", 0, 1, mk(4'b1000, 3, 2), 0, 1, 16'h3333, 0, 0, 16'h0);
    // R8 overflow on stack 2
    for (int k = 0; k < 18; k++)
      step("R8", 0, 1, mk(4'b0001, 2, 0), 0, 1, 16'h8000 + 16'(k), 0, 0, 16'h0);
    for (int k = 0; k < 17; k++)
      step("R8", 0, 1, mk(4'b1000, 3, 2), 0, 0, 16'h0, 0, 0, 16'h0);
    // R9 R10 interrupt path
    step("R9", 0, 0, 16'h0, 0, 0, 16'h0, 1, 0, 16'hABCD);
    step("R10", 0, 1, mk(4'b0000, 0, 0), 1, 1, 16'h7777, 1, 0, 16'h1234);
    step("R10", 0, 1, mk(4'b0000, 0, 0), 1, 1, 16'h7777, 1, 1, 16'h4321);
    step("R9", 0, 0, 16'h0, 0, 0, 16'h0, 0, 1, 16'h0);
    step("R9", 0, 1, mk(4'b1111, 0, 0), 0, 0, 16'h0, 0, 0, 16'h0);
    for (int k = 0; k < 4; k++)
      step("R9", 0, 0, 16'h0, 0, 0, 16'h0, 0, 1, 16'h0);
    step("R11", 1, 0, 16'h0, 0, 0, 16'h0, 0, 0, 16'h0);
    step("R11", 0, 1, mk(4'b1111, 1, 2), 0, 0, 16'h0, 0, 0, 16'h0);
    // R12 mixed traffic on all stacks
    for (int k = 0; k < 1500; k++) begin
      logic [31:0] x;
      x = $urandom;
      step("R12", (k % 700) == 699, x[16], x[15:0], x[17], x[18], x[31:16],
           x[22:19] == 0, x[26:23] == 0, ~x[31:16]);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule